// File: doc/BRIEF.md
# Line-Rate Sandcastle Pulse Generator

This block builds the composite blanking and burst-gate waveform of a display deflection controller, one level code per cycle of a line-locked sample clock. Each rising edge of the horizontal sync input starts a new line. A position counter then runs through the line. Two windows are placed on that counter: the burst gate and the programmed horizontal blanking. Their positions come from fixed arithmetic on 6-bit control fields. The burst window's offset depends on a clock-mode select.

Horizontal blanking has two sources. It can follow the flyback input directly, or it can use the programmed window. A vertical blanking window can be merged into the blanking level, and a disable bit removes blanking altogether. All control fields are captured once per line, at line start. Each line is therefore built from one coherent set of settings.

Top module: `sandcastle_gen`

## Requirements
- R1: After reset, and until the first rising edge of `hsync_i` is sampled, `level_o` is the low code, whatever the flyback and vertical-blanking inputs do.
- R2: The clock edge that first samples `hsync_i` high after it was low is line edge 0, and the line position restarts there at 0. The level for line position n appears on `level_o` after line edge n+1. Flyback and vertical blanking sampled at edge n act at that same position. Holding `hsync_i` high does not restart the line again.
- R3: The output codes are 2'b10 for burst, 2'b01 for blanking and 2'b00 for low. The code 2'b11 never appears.
- R4: The burst gate covers 54 positions, starting at D = 76 − 4·sync_phase when `clk_fast_i` = 0 and at D = 38 − 4·sync_phase when `clk_fast_i` = 1.
- R5: With `blank_prog_i` = 1, horizontal blanking covers 4·width + 1 positions. It starts at S = hshift + 4·pos − 2·width + 43.
- R6: With `blank_prog_i` = 0, horizontal blanking is present at exactly those positions where `flyback_i` was sampled high.
- R7: With `blank_off_i` = 1, the blanking code never appears (neither horizontal nor vertical blanking), while the burst gate is unaffected.
- R8: With `vblank_merge_i` = 1, every position where `vblank_i` was sampled high carries the blanking code. With `vblank_merge_i` = 0, `vblank_i` has no effect.
- R9: Where the burst gate and any blanking overlap, the burst code wins.
- R10: All control fields are captured at line edge 0. A change during a line alters nothing until the next line.
- R11: A start below 0 is clamped to 0, and a start at or beyond LINE_LEN is clamped to LINE_LEN−1. Every window ends no later than LINE_LEN. Past LINE_LEN the position stops, and no window is active until the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line-locked sample clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Horizontal sync; rising edge starts a line |
| flyback_i | input | 1 | Horizontal flyback pulse |
| vblank_i | input | 1 | Vertical blanking window |
| blank_off_i | input | 1 | Suppresses all blanking |
| blank_prog_i | input | 1 | 0: flyback blanking, 1: programmed blanking |
| hbl_width_i | input | FW | Programmed blanking width field |
| hbl_pos_i | input | FW | Programmed blanking phase field |
| hshift_i | input | FW | Horizontal shift field |
| sync_phase_i | input | FW | Internal sync phase field for burst delay |
| vblank_merge_i | input | 1 | Merges vertical blanking into the output |
| clk_fast_i | input | 1 | Clock-mode select for the burst offset |
| level_o | output | 2 | Output level code |

## Verification
The burst gate and horizontal blanking (programmed, flyback or vertical) can claim the same position, and in that case the output must show the burst code. The bench provokes the overlap in two ways. First, it sweeps every sync phase in both clock modes while the blanking fields move, so that the programmed window slides across the burst window. Second, it runs lines with flyback or vertical blanking held over the burst region. At every position it judges the output against arithmetic it computes itself, with burst taking precedence.

// File: rtl/sc_pkg.sv
package sc_pkg;

  typedef enum logic [1:0] {
    LVL_LOW   = 2'b00,
    LVL_BLANK = 2'b01,
    LVL_BURST = 2'b10
  } sc_level_e;

  // Limit a signed position to the range [0, hi]
  function automatic int sc_clamp(input int v, input int hi);
    if (v < 0)  return 0;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/sc_timing_calc.sv
module sc_timing_calc #(
  parameter int FW          = 6,
  parameter int LINE_LEN    = 1024,
  parameter int CNT_W       = 11,
  parameter int BG_OFS_SLOW = 76,
  parameter int BG_OFS_FAST = 38,
  parameter int BG_WIDTH    = 54,
  parameter int HBL_OFS     = 43
) (
  input  logic [FW-1:0]    hbl_width_i,
  input  logic [FW-1:0]    hbl_pos_i,
  input  logic [FW-1:0]    hshift_i,
  input  logic [FW-1:0]    sync_phase_i,
  input  logic             clk_fast_i,
  output logic [CNT_W-1:0] hb_start_o,
  output logic [CNT_W-1:0] hb_end_o,
  output logic [CNT_W-1:0] bg_start_o,
  output logic [CNT_W-1:0] bg_end_o
);
  import sc_pkg::*;

  int hs, he, bs, be, w, p, sh, sp;

  always_comb begin
    w  = int'(hbl_width_i);
    p  = int'(hbl_pos_i);
    sh = int'(hshift_i);
    sp = int'(sync_phase_i);

    hs = sc_clamp(sh + 4 * p - 2 * w + HBL_OFS, LINE_LEN - 1);
    he = hs + 4 * w + 1;
    if (he > LINE_LEN) he = LINE_LEN;

    bs = sc_clamp((clk_fast_i ? BG_OFS_FAST : BG_OFS_SLOW) - 4 * sp, LINE_LEN - 1);
    be = bs + BG_WIDTH;
    if (be > LINE_LEN) be = LINE_LEN;

    hb_start_o = CNT_W'(hs);
    hb_end_o   = CNT_W'(he);
    bg_start_o = CNT_W'(bs);
    bg_end_o   = CNT_W'(be);
  end

endmodule

// File: rtl/sc_line_counter.sv
module sc_line_counter #(
  parameter int LINE_LEN = 1024,
  parameter int CNT_W    = 11
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             hsync_i,
  output logic             line_start_o,
  output logic [CNT_W-1:0] pos_o,
  output logic             started_o
);
  localparam logic [CNT_W-1:0] POS_MAX = CNT_W'(LINE_LEN);

  logic hs_q;

  assign line_start_o = hsync_i && !hs_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hs_q      <= 1'b0;
      pos_o     <= POS_MAX;
      started_o <= 1'b0;
    end else begin
      hs_q <= hsync_i;
      if (line_start_o) begin
        pos_o     <= '0;
        started_o <= 1'b1;
      end else if (pos_o < POS_MAX) begin
        pos_o <= pos_o + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sc_window.sv
module sc_window #(
  parameter int CNT_W = 11
) (
  input  logic [CNT_W-1:0] pos_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] end_i,
  output logic             hit_o
);
  assign hit_o = (pos_i >= start_i) && (pos_i < end_i);
endmodule

// File: rtl/sandcastle_gen.sv
module sandcastle_gen #(
  parameter int FW          = 6,
  parameter int LINE_LEN    = 1024,
  parameter int BG_OFS_SLOW = 76,
  parameter int BG_OFS_FAST = 38,
  parameter int BG_WIDTH    = 54,
  parameter int HBL_OFS     = 43
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          hsync_i,
  input  logic          flyback_i,
  input  logic          vblank_i,
  input  logic          blank_off_i,
  input  logic          blank_prog_i,
  input  logic [FW-1:0] hbl_width_i,
  input  logic [FW-1:0] hbl_pos_i,
  input  logic [FW-1:0] hshift_i,
  input  logic [FW-1:0] sync_phase_i,
  input  logic          vblank_merge_i,
  input  logic          clk_fast_i,
  output logic [1:0]    level_o
);
  import sc_pkg::*;

  localparam int CNT_W = $clog2(LINE_LEN + 1);
  localparam int NWIN  = 2;   // 0: burst gate, 1: programmed blanking

  logic             line_start, started;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] hb_s_c, hb_e_c, bg_s_c, bg_e_c;

  // per-line shadow state
  logic [CNT_W-1:0] win_s_q [NWIN];
  logic [CNT_W-1:0] win_e_q [NWIN];
  logic             dis_q, src_q, vbe_q;
  logic             fly_q, vb_q;
  logic [NWIN-1:0]  win_hit;
  logic             bg_hit, hb_hit, blank_c;

  sc_line_counter #(.LINE_LEN(LINE_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .hsync_i     (hsync_i),
    .line_start_o(line_start),
    .pos_o       (pos),
    .started_o   (started)
  );

  sc_timing_calc #(
    .FW(FW), .LINE_LEN(LINE_LEN), .CNT_W(CNT_W),
    .BG_OFS_SLOW(BG_OFS_SLOW), .BG_OFS_FAST(BG_OFS_FAST),
    .BG_WIDTH(BG_WIDTH), .HBL_OFS(HBL_OFS)
  ) u_calc (
    .hbl_width_i (hbl_width_i),
    .hbl_pos_i   (hbl_pos_i),
    .hshift_i    (hshift_i),
    .sync_phase_i(sync_phase_i),
    .clk_fast_i  (clk_fast_i),
    .hb_start_o  (hb_s_c),
    .hb_end_o    (hb_e_c),
    .bg_start_o  (bg_s_c),
    .bg_end_o    (bg_e_c)
  );

  // Field capture: once per line, at the sync edge
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < NWIN; i++) begin
        win_s_q[i] <= '0;
        win_e_q[i] <= '0;
      end
      dis_q <= 1'b0;
      src_q <= 1'b0;
      vbe_q <= 1'b0;
    end else if (line_start) begin
      win_s_q[0] <= bg_s_c;
      win_e_q[0] <= bg_e_c;
      win_s_q[1] <= hb_s_c;
      win_e_q[1] <= hb_e_c;
      dis_q      <= blank_off_i;
      src_q      <= blank_prog_i;
      vbe_q      <= vblank_merge_i;
    end
  end

  // Level inputs aligned with the position counter
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fly_q <= 1'b0;
      vb_q  <= 1'b0;
    end else begin
      fly_q <= flyback_i;
      vb_q  <= vblank_i;
    end
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    sc_window #(.CNT_W(CNT_W)) u_win (
      .pos_i  (pos),
      .start_i(win_s_q[w]),
      .end_i  (win_e_q[w]),
      .hit_o  (win_hit[w])
    );
  end

  assign bg_hit  = win_hit[0];
  assign hb_hit  = win_hit[1];
  assign blank_c = !dis_q && ((src_q ? hb_hit : fly_q) || (vbe_q && vb_q));

  always_ff @(posedge clk_i) begin
    if (rst_i || !started) level_o <= LVL_LOW;
    else if (bg_hit)       level_o <= LVL_BURST;
    else if (blank_c)      level_o <= LVL_BLANK;
    else                   level_o <= LVL_LOW;
  end

endmodule

// File: rtl/sandcastle_gen_chk.sv
module sandcastle_gen_chk #(
  parameter int CNT_W    = 11,
  parameter int LINE_LEN = 1024,
  parameter int BG_WIDTH = 54
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [1:0]       level_o,
  input logic             started,
  input logic             line_start,
  input logic [CNT_W-1:0] pos,
  input logic             dis_q,
  input logic             src_q,
  input logic             vbe_q,
  input logic             fly_q,
  input logic             vb_q,
  input logic             bg_hit,
  input logic             hb_hit
);
  logic             ls_d1, ls_d2;
  logic [CNT_W:0]   run;

  // length of the current burst run as seen on the output
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ls_d1 <= 1'b0;
      ls_d2 <= 1'b0;
      run   <= '0;
    end else begin
      ls_d1 <= line_start;
      ls_d2 <= ls_d1;
      if (level_o == 2'b10) run <= ls_d2 ? (CNT_W+1)'(1) : run + 1'b1;
      else                  run <= '0;
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    !started |=> level_o == 2'b00);

  assert_code_valid_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    level_o != 2'b11);

  assert_burst_len_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    run <= (CNT_W+1)'(BG_WIDTH));

  assert_prog_blank_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (started && !dis_q && src_q && hb_hit && !bg_hit) |=> level_o == 2'b01);

  assert_flyback_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (started && !dis_q && !src_q && fly_q && !bg_hit) |=> level_o == 2'b01);

  assert_disable_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (started && dis_q) |=> level_o != 2'b01);

  assert_vblank_merge_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (started && !dis_q && vbe_q && vb_q && !bg_hit) |=> level_o == 2'b01);

  assert_burst_priority_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (started && bg_hit) |=> level_o == 2'b10);

  assert_pos_range_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    pos <= CNT_W'(LINE_LEN));

endmodule

bind sandcastle_gen sandcastle_gen_chk #(
  .CNT_W(CNT_W), .LINE_LEN(LINE_LEN), .BG_WIDTH(BG_WIDTH)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .level_o   (level_o),
  .started   (started),
  .line_start(line_start),
  .pos       (pos),
  .dis_q     (dis_q),
  .src_q     (src_q),
  .vbe_q     (vbe_q),
  .fly_q     (fly_q),
  .vb_q      (vb_q),
  .bg_hit    (bg_hit),
  .hb_hit    (hb_hit)
);

// File: tb/sim_sandcastle_gen.sv
`timescale 1ns/1ps
module sim_sandcastle_gen;
  localparam int L  = 160;
  localparam int FW = 6;

  logic clk = 1'b0;
  logic rst, hsync, fly, vb, dis, src, vbe, fast;
  logic [FW-1:0] f_w, f_p, f_sh, f_sp;
  logic [1:0] level;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sandcastle_gen #(.FW(FW), .LINE_LEN(L)) u0 (
    .clk_i(clk), .rst_i(rst), .hsync_i(hsync), .flyback_i(fly), .vblank_i(vb),
    .blank_off_i(dis), .blank_prog_i(src), .hbl_width_i(f_w), .hbl_pos_i(f_p),
    .hshift_i(f_sh), .sync_phase_i(f_sp), .vblank_merge_i(vbe), .clk_fast_i(fast),
    .level_o(level)
  );

  function automatic int clampv(int v, int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  // independent model of the level at line position n
  function automatic int exp_lvl(int n, int d, int s, int ve, int md, int sp,
                                 int w, int p, int sh, int fl, int vv);
    int bs, be, hs, he, bl;
    bs = clampv((md != 0 ? 38 : 76) - 4 * sp, L - 1);
    be = (bs + 54 > L) ? L : bs + 54;
    hs = clampv(sh + 4 * p - 2 * w + 43, L - 1);
    he = (hs + 4 * w + 1 > L) ? L : hs + 4 * w + 1;
    if (n >= bs && n < be) return 2;
    bl = (d == 0) && (((s != 0) ? (n >= hs && n < he) : (fl != 0)) ||
                      ((ve != 0) && (vv != 0)));
    return bl ? 1 : 0;
  endfunction

  // next-line values applied at position chg_k of a line (when chg_k >= 0)
  logic [FW-1:0] nw, np, nsh, nsp;

  task automatic run_line(input string tag, input int len, input int hs_len,
                          input int fs, input int fe, input int vbin, input int chg_k);
    int d, s, ve, md, sp, w, p, sh, got, ex, bad, bn, ba, be;
    d = dis; s = src; ve = vbe; md = fast; sp = f_sp; w = f_w; p = f_p; sh = f_sh;
    bad = 0; bn = 0; ba = 0; be = 0;
    for (int k = 0; k < len; k++) begin
      hsync = (k < hs_len);
      fly   = (k >= fs && k < fe);
      vb    = vbin[0];
      if (k == chg_k) begin
        f_w = nw; f_p = np; f_sh = nsh; f_sp = nsp;
        dis = ~dis; src = ~src; vbe = ~vbe; fast = ~fast;
      end
      @(posedge clk);
      @(negedge clk);
      if (k >= 1 && k - 1 <= len - 2) begin
        got = int'(level);
        ex  = exp_lvl(k - 1, d, s, ve, md, sp, w, p, sh,
                      ((k - 1) >= fs && (k - 1) < fe) ? 1 : 0, vbin);
        if (got != ex && bad == 0) begin
          bad = 1; bn = k - 1; ba = got; be = ex;
        end
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: position %0d actual %0d expected %0d", tag, bn, ba, be);
    end
  endtask

  task automatic set_fields(int d, int s, int ve, int md, int sp, int w, int p, int sh);
    dis = d[0]; src = s[0]; vbe = ve[0]; fast = md[0];
    f_sp = FW'(sp); f_w = FW'(w); f_p = FW'(p); f_sh = FW'(sh);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; hsync = 0; fly = 0; vb = 0;
    set_fields(0, 0, 1, 0, 0, 0, 0, 0);
    nw = 0; np = 0; nsh = 0; nsp = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (level !== 2'b00) begin
      errors++;
      $display("FAIL R1 reset: actual %b expected 00", level);
    end
    rst = 1'b0;
    // R1: no output before the first sync despite flyback and vblank
    fly = 1; vb = 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      checks++;
      if (level !== 2'b00) begin
        errors++;
        $display("FAIL R1 pre-sync cycle %0d: actual %b expected 00", i, level);
      end
    end
    fly = 0; vb = 0;
    @(negedge clk);

    // R4 R5 R9 R11 R3: sweep sync phase in both clock modes, moving blanking fields
    for (int i = 0; i < 128; i++) begin
      set_fields(0, 1, 0, i / 64, i % 64, (i * 5) % 64, (i * 11) % 64, (i * 23) % 64);
      run_line("R4 R5 R9 sweep", 170, 4, 0, 0, 0, -1);
    end

    // R11: start clamped to 0 (negative) and to L-1 (too large)
    set_fields(0, 1, 0, 0, 63, 63, 0, 0);
    run_line("R11 low clamp", 170, 4, 0, 0, 0, -1);
    set_fields(0, 1, 0, 1, 0, 20, 63, 63);
    run_line("R11 high clamp", 170, 4, 0, 0, 0, -1);

    // R6: flyback-following blanking, overlapping the burst (R9)
    set_fields(0, 0, 0, 0, 0, 10, 10, 10);
    run_line("R6 flyback", 170, 4, 100, 130, 0, -1);
    run_line("R6 R9 flyback over burst", 170, 4, 60, 90, 0, -1);

    // R8: vertical blanking merged, then ignored
    set_fields(0, 1, 1, 1, 2, 3, 4, 5);
    run_line("R8 merged", 170, 4, 0, 0, 1, -1);
    set_fields(0, 1, 0, 1, 2, 3, 4, 5);
    run_line("R8 ignored", 170, 4, 0, 0, 1, -1);

    // R7: disable suppresses every blanking source, burst stays
    set_fields(1, 0, 1, 0, 5, 3, 4, 5);
    run_line("R7 disable flyback", 170, 4, 20, 150, 1, -1);
    set_fields(1, 1, 1, 1, 1, 30, 20, 5);
    run_line("R7 disable programmed", 170, 4, 0, 0, 1, -1);

    // R2: long sync pulse does not retrigger; short line restarts cleanly
    set_fields(0, 1, 0, 1, 0, 8, 2, 0);
    run_line("R2 long sync", 170, 40, 0, 0, 0, -1);
    run_line("R2 short line", 60, 4, 0, 0, 0, -1);
    run_line("R2 after short line", 170, 4, 0, 0, 0, -1);

    // R10: mid-line change holds until the next line
    set_fields(0, 1, 0, 0, 3, 6, 9, 12);
    nw = 40; np = 2; nsh = 1; nsp = 10;
    run_line("R10 mid-line change", 170, 4, 0, 0, 0, 25);
    run_line("R10 next line", 170, 4, 0, 0, 0, -1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule